// File: doc/BRIEF.md
# 32-bit SEC-DED Error Corrector

This combinational block guards a 32-bit memory word with a 7-bit check word. When the
word is being written, the block forms the check word from the data, and the memory stores
it next to the data. When the word is read back, the block takes the 39 stored bits and
returns four results:

- the data, with any single data-bit error repaired;
- the 7-bit syndrome, shown on the check output in place of the check word;
- an active-low single-error flag;
- an active-low multiple-error flag.

A separate block sequences the modes and holds the latches. This block has no clock and no state.

Every check bit is the parity of exactly 16 data bits. Each data bit has a syndrome column
of weight three or five, so the weight of the syndrome tells single errors apart from double
errors. Check bits 0 and 3 are stored inverted. Because of this, a word that is stuck at all
zeros or stuck at all ones can never look clean.

Top module: `edac_sec_ded`

## Requirements
- R1: With `rd_mode` low, `chk_out` is the generated check word. For each row r, bit r is the XOR of the data bits whose column has bit r set, XOR bit r of 7'h09. `data_out` equals `data_in`, and both flags are high.
- R2: The column of data bit j, for j from 0 to 31 and written in hex, is 07 0E 1C 38 70 61 43 0B 16 2C 58 31 62 45 23 46 0D 1A 34 68 51 7A 75 6B 57 2F 5E 3D 13 25 4A 7C. All columns are distinct and have weight 3 or 5. Every row contains 16 ones.
- R3: With `rd_mode` high, `chk_out` carries the syndrome, which is `chk_in` XOR the check word generated from `data_in`.
- R4: A clean word, meaning a zero syndrome, gives both flags high and `data_out` equal to `data_in`.
- R5: A single data-bit error makes the syndrome equal to that bit's column. The block then drives `err_n` low, holds `merr_n` high and inverts that one bit in `data_out`.
- R6: A single check-bit error makes the syndrome one-hot. The block drives `err_n` low, holds `merr_n` high and passes `data_out` through unchanged.
- R7: Any two-bit error among the 39 bits gives a nonzero syndrome of even weight. Both flags go low and the data is passed through uncorrected.
- R8: An odd-weight syndrome that matches no column and is not one-hot drives both flags low, and the data is passed through uncorrected.
- R9: A 39-bit input of all zeros reads with syndrome 7'h09. A 39-bit input of all ones reads with syndrome 7'h76. In both cases both flags are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_in | input | 32 | Data word, either to be written or as read from memory |
| chk_in | input | 7 | Check word as read from memory (ignored in write mode) |
| rd_mode | input | 1 | 1: check and correct; 0: generate a check word |
| data_out | output | 32 | Corrected data (read mode) or `data_in` (write mode) |
| chk_out | output | 7 | Syndrome (read mode) or generated check word (write mode) |
| err_n | output | 1 | Low when any error is detected |
| merr_n | output | 1 | Low when the error cannot be corrected |

## Verification
The patterns fall into six groups:

- **Walking ones in write mode.** These isolate each parity column, so an error in any one matrix entry shows up on its own.
- **Encoded words flipped at every one of the 39 positions.** These separate data repair from check-bit-only reporting.
- **Every pair of flipped positions.** This covers two base words and separates even-weight syndromes from correctable ones.
- **The stuck-at-zero and stuck-at-one words.** These show that the inversion mask keeps gross failures from reading as clean.
- **Triple flips.** These reach the syndromes that match no column.
- **Random clean words and single flips.** These exercise the parity trees with mixed data.

// File: rtl/edac_pkg.sv
package edac_pkg;

   localparam int unsigned EDAC_DATA_W = 32;
   localparam int unsigned EDAC_CHK_W  = 7;
   // check bits 0 and 3 stored inverted: all-0 / all-1 words never decode clean
   localparam logic [EDAC_CHK_W-1:0] EDAC_INV = 7'h09;

   function automatic logic [EDAC_CHK_W-1:0] rot7(input logic [EDAC_CHK_W-1:0] v,
                                                  input int unsigned s);
      logic [EDAC_CHK_W-1:0] r;
      r = '0;
      for (int unsigned i = 0; i < EDAC_CHK_W; i++)
         r[(i + s) % EDAC_CHK_W] = v[i];
      return r;
   endfunction

   // Column of data bit j: three full rotation orbits of weight-3 patterns,
   // one full orbit of weight-5 patterns, and four fill-in columns that
   // bring every row to 16 ones.
   function automatic logic [EDAC_CHK_W-1:0] edac_column(input int unsigned j);
      logic [EDAC_CHK_W-1:0] base;
      if (j < 21) begin
         case (j / 7)
            0:       base = 7'b0000111;
            1:       base = 7'b0001011;
            default: base = 7'b0100011;
         endcase
         return rot7(base, j % 7);
      end else if (j < 28) begin
         return rot7(7'b1111010, j - 21);
      end else begin
         case (j)
            28:      return 7'h13;
            29:      return 7'h25;
            30:      return 7'h4A;
            default: return 7'h7C;
         endcase
      end
   endfunction

   function automatic logic [EDAC_DATA_W-1:0] edac_row_mask(input int unsigned r);
      logic [EDAC_DATA_W-1:0] m;
      logic [EDAC_CHK_W-1:0]  c;
      m = '0;
      for (int unsigned j = 0; j < EDAC_DATA_W; j++) begin
         c    = edac_column(j);
         m[j] = c[r];
      end
      return m;
   endfunction

endpackage

// File: rtl/edac_parity_gen.sv
module edac_parity_gen
   import edac_pkg::*;
#(
   parameter int unsigned           DATA_W   = EDAC_DATA_W,
   parameter int unsigned           CHK_W    = EDAC_CHK_W,
   parameter logic [CHK_W-1:0]      INV_MASK = EDAC_INV
) (
   input  logic [DATA_W-1:0] data_i,
   output logic [CHK_W-1:0]  chk_o
);

   localparam int unsigned ROW_ONES = DATA_W / 2;

   initial begin
      AST_GEN_SHAPE: assert (DATA_W == EDAC_DATA_W && CHK_W == EDAC_CHK_W)
         else $error("parity generator supports only the 32/7 matrix"); // R2
   end

   for (genvar r = 0; r < CHK_W; r++) begin : g_row
      localparam logic [DATA_W-1:0] ROW_MASK = edac_row_mask(r);

      initial begin
         AST_ROW_WEIGHT: assert ($countones(ROW_MASK) == ROW_ONES)
            else $error("row %0d does not cover half the data bits", r); // R2
      end

      assign chk_o[r] = (^(data_i & ROW_MASK)) ^ INV_MASK[r];
   end

endmodule

// File: rtl/edac_syn_decode.sv
module edac_syn_decode
   import edac_pkg::*;
#(
   parameter int unsigned DATA_W = EDAC_DATA_W,
   parameter int unsigned CHK_W  = EDAC_CHK_W
) (
   input  logic [CHK_W-1:0]  syn_i,
   output logic [DATA_W-1:0] flip_o,
   output logic              err_n_o,
   output logic              merr_n_o
);

   logic syn_zero;
   logic syn_chk_only;
   logic syn_data_hit;

   initial begin
      for (int unsigned i = 0; i < DATA_W; i++) begin
         AST_COL_WEIGHT: assert ($countones(edac_column(i)) == 3 ||
                                 $countones(edac_column(i)) == 5)
            else $error("column %0d has even or wrong weight", i); // R2
         for (int unsigned k = i + 1; k < DATA_W; k++) begin
            AST_COL_UNIQUE: assert (edac_column(i) != edac_column(k))
               else $error("columns %0d and %0d collide", i, k); // R2
         end
      end
   end

   for (genvar j = 0; j < DATA_W; j++) begin : g_col
      localparam logic [CHK_W-1:0] COL = edac_column(j);
      assign flip_o[j] = (syn_i == COL);
   end

   assign syn_zero     = (syn_i == '0);
   assign syn_chk_only = $onehot(syn_i);
   assign syn_data_hit = |flip_o;

   assign err_n_o  = syn_zero;
   assign merr_n_o = syn_zero | syn_chk_only | syn_data_hit;

   always_comb begin
      AST_FLIP_ONEHOT: assert ($onehot0(flip_o))
         else $error("more than one data bit selected for repair"); // R5
      AST_EVEN_NO_FIX: assert (!(!syn_zero && !(^syn_i)) || (flip_o == '0 && !merr_n_o))
         else $error("even syndrome treated as correctable"); // R7
      AST_SINGLE_ODD: assert (!(!err_n_o && merr_n_o) || (^syn_i))
         else $error("correctable flag with even syndrome"); // R8
   end

endmodule

// File: rtl/edac_sec_ded.sv
module edac_sec_ded
   import edac_pkg::*;
#(
   parameter int unsigned DATA_W = EDAC_DATA_W,
   parameter int unsigned CHK_W  = EDAC_CHK_W
) (
   input  logic [DATA_W-1:0] data_in,
   input  logic [CHK_W-1:0]  chk_in,
   input  logic              rd_mode,
   output logic [DATA_W-1:0] data_out,
   output logic [CHK_W-1:0]  chk_out,
   output logic              err_n,
   output logic              merr_n
);

   logic [CHK_W-1:0]  gen_chk;
   logic [CHK_W-1:0]  syndrome;
   logic [DATA_W-1:0] flip;
   logic              dec_err_n;
   logic              dec_merr_n;

   initial begin
      AST_TOP_SHAPE: assert (DATA_W == EDAC_DATA_W && CHK_W == EDAC_CHK_W)
         else $error("unsupported width pair"); // R2
   end

   edac_parity_gen #(
      .DATA_W   (DATA_W),
      .CHK_W    (CHK_W),
      .INV_MASK (EDAC_INV)
   ) i_gen (
      .data_i (data_in),
      .chk_o  (gen_chk)
   );

   assign syndrome = chk_in ^ gen_chk;

   edac_syn_decode #(
      .DATA_W (DATA_W),
      .CHK_W  (CHK_W)
   ) i_dec (
      .syn_i    (syndrome),
      .flip_o   (flip),
      .err_n_o  (dec_err_n),
      .merr_n_o (dec_merr_n)
   );

   assign data_out = rd_mode ? (data_in ^ flip) : data_in;
   assign chk_out  = rd_mode ? syndrome : gen_chk;
   assign err_n    = rd_mode ? dec_err_n  : 1'b1;
   assign merr_n   = rd_mode ? dec_merr_n : 1'b1;

   always_comb begin
      AST_WRITE_QUIET: assert (rd_mode || (err_n && merr_n && data_out == data_in))
         else $error("write mode disturbed data or flags"); // R1
      AST_CLEAN_PASS: assert (!(rd_mode && err_n) || (merr_n && data_out == data_in && chk_out == '0))
         else $error("clean read altered"); // R4
      AST_CHKERR_NO_FIX: assert (!(rd_mode && $onehot(chk_out)) || (data_out == data_in && !err_n && merr_n))
         else $error("check-bit error touched data"); // R6
      AST_UNCORR_PASS: assert (!(rd_mode && !merr_n) || (!err_n && data_out == data_in))
         else $error("uncorrectable word modified"); // R8
   end

endmodule

// File: tb/test_edac_sec_ded.sv
module test_edac_sec_ded;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] data_in = '0;
   logic [6:0]  chk_in = '0;
   logic        rd_mode = 1'b0;
   logic [31:0] data_out;
   logic [6:0]  chk_out;
   logic        err_n;
   logic        merr_n;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   logic [6:0] cols [32];

   always #5 clk = ~clk;

   edac_sec_ded i_edac_sec_ded (
      .data_in (data_in), .chk_in (chk_in), .rd_mode (rd_mode),
      .data_out (data_out), .chk_out (chk_out), .err_n (err_n), .merr_n (merr_n)
   );

   // behavioural reference: column table written out per R2
   function automatic logic [6:0] ref_gen(input logic [31:0] d);
      logic [6:0] p = 7'h09;
      for (int j = 0; j < 32; j++) if (d[j]) p ^= cols[j];
      return p;
   endfunction

   task automatic ref_model(input logic [31:0] d, input logic [6:0] c, input logic rd,
                            output logic [31:0] ed, output logic [6:0] ec,
                            output logic ee, output logic em);
      logic [6:0] s;
      ed = d; ee = 1'b1; em = 1'b1;
      if (!rd) begin
         ec = ref_gen(d);
         return;
      end
      s  = c ^ ref_gen(d);
      ec = s;
      if (s == 0) return;
      ee = 1'b0;
      if ($countones(s) == 1) return;
      for (int j = 0; j < 32; j++)
         if (cols[j] == s) begin
            ed[j] = ~ed[j];
            return;
         end
      em = 1'b0;
   endtask

   task automatic apply(input logic [31:0] d, input logic [6:0] c, input logic rd,
                        input string tag);
      logic [31:0] ed; logic [6:0] ec; logic ee, em;
      @(posedge clk);
      #1;
      data_in = d; chk_in = c; rd_mode = rd;
      ref_model(d, c, rd, ed, ec, ee, em);
      @(negedge clk);
      checks++;
      if (data_out !== ed || chk_out !== ec || err_n !== ee || merr_n !== em) begin
         failures++;
         $display("FAIL %s: rd=%0b din=%h cin=%h got data=%h chk=%h err_n=%b merr_n=%b exp data=%h chk=%h err_n=%b merr_n=%b",
                  tag, rd, d, c, data_out, chk_out, err_n, merr_n, ed, ec, ee, em);
      end
   endtask

   task automatic expect_lit(input logic [6:0] es, input logic ee, input logic em,
                             input string tag);
      checks++;
      if (chk_out !== es || err_n !== ee || merr_n !== em) begin
         failures++;
         $display("FAIL %s: got chk=%h err_n=%b merr_n=%b exp chk=%h err_n=%b merr_n=%b",
                  tag, chk_out, err_n, merr_n, es, ee, em);
      end
   endtask

   task automatic flip39(input logic [31:0] d, input logic [6:0] c, input int p,
                         output logic [31:0] od, output logic [6:0] oc);
      od = d; oc = c;
      if (p < 32) od[p] = ~od[p];
      else oc[p-32] = ~oc[p-32];
   endtask

   initial begin
      logic [31:0] base [3];
      cols = '{7'h07, 7'h0E, 7'h1C, 7'h38, 7'h70, 7'h61, 7'h43, 7'h0B,
               7'h16, 7'h2C, 7'h58, 7'h31, 7'h62, 7'h45, 7'h23, 7'h46,
               7'h0D, 7'h1A, 7'h34, 7'h68, 7'h51, 7'h7A, 7'h75, 7'h6B,
               7'h57, 7'h2F, 7'h5E, 7'h3D, 7'h13, 7'h25, 7'h4A, 7'h7C};
      base = '{32'hDEAD_BEEF, 32'h0000_0001, 32'h8421_F00C};

      repeat (4) @(posedge clk);
      @(negedge clk);
      expect_lit(7'h09, 1'b1, 1'b1, "R1 reset state zero word");
      rst_n = 1'b1;

      // R1 / R2: walking ones expose each column
      for (int j = 0; j < 32; j++) apply(32'h1 << j, 7'h55, 1'b0, "R2 walking one");
      for (int k = 0; k < 3; k++) apply(base[k], 7'h00, 1'b0, "R1 write");
      apply(32'hFFFF_FFFF, 7'h7F, 1'b0, "R1 write ones");

      // R3 / R4: clean reads
      for (int k = 0; k < 3; k++) apply(base[k], ref_gen(base[k]), 1'b1, "R4 clean read");

      // R5 / R6: every single flip
      for (int k = 0; k < 3; k++)
         for (int p = 0; p < 39; p++) begin
            logic [31:0] d; logic [6:0] c;
            flip39(base[k], ref_gen(base[k]), p, d, c);
            apply(d, c, 1'b1, p < 32 ? "R5 single data error" : "R6 single check error");
         end

      // R7: every pair of flips on two words
      for (int k = 0; k < 2; k++)
         for (int p = 0; p < 39; p++)
            for (int q = p + 1; q < 39; q++) begin
               logic [31:0] d; logic [6:0] c;
               flip39(base[k], ref_gen(base[k]), p, d, c);
               flip39(d, c, q, d, c);
               apply(d, c, 1'b1, "R7 double error");
            end

      // R8: triple flips reach unmatched odd syndromes
      for (int p = 0; p < 37; p++) begin
         logic [31:0] d; logic [6:0] c;
         flip39(base[2], ref_gen(base[2]), p, d, c);
         flip39(d, c, p + 1, d, c);
         flip39(d, c, p + 2, d, c);
         apply(d, c, 1'b1, "R8 triple error");
      end

      // R9: gross failures, literal expectations
      apply(32'h0, 7'h00, 1'b1, "R9 all zeros");
      expect_lit(7'h09, 1'b0, 1'b0, "R9 all zeros literal");
      apply(32'hFFFF_FFFF, 7'h7F, 1'b1, "R9 all ones");
      expect_lit(7'h76, 1'b0, 1'b0, "R9 all ones literal");

      // R3: random mixed words
      for (int n = 0; n < 400; n++) begin
         logic [31:0] d; logic [6:0] c;
         d = $urandom;
         c = ref_gen(d);
         if (n % 2 == 1) flip39(d, c, $urandom_range(38, 0), d, c);
         apply(d, c, 1'b1, "R3 random syndrome");
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: run did not finish, got timeout exp completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule